// File: doc/BRIEF.md
# Protected Interrupt Vector Relocation Control

This block holds the bit that decides whether the interrupt vector table sits at the start of the application region or at the start of the boot region. It drives the matching vector base address to the interrupt controller. Software cannot flip that bit with a single store. A first write must set an arming bit. Only a second write, made within a short fixed window of clock cycles and carrying a zero in the arming bit, may load the new selection. Every other write leaves the selection untouched.

While the window is open, and after a successful relocation until the next instruction retires, the block raises a hardware interrupt mask. This mask is separate from the processor's global interrupt-enable flag and has no path to it. The block also applies a standing mask whenever the vectors live in one region, execution is in the other region, and the lock option protecting the vector-holding region is active.

Top module: `ivt_reloc`

## Requirements
- R1: After reset the selection output is 0, the vector base is 0 and the mask output is 0 (with both lock inputs low).
- R2: A write with the arming bit at 1 opens the window, and the mask output reads 1 from the first cycle after that write's clock edge.
- R3: A write with the arming bit at 0 loads the select data bit into the selection when it is presented in any of the four cycles that follow the arming write's edge.
- R4: A write inside the window with the arming bit at 1 leaves the selection unchanged and restarts the four-cycle count.
- R5: A write with the arming bit at 0 while no window is open leaves the selection unchanged.
- R6: With no write, the window closes and the mask output returns to 0 four cycles after the arming edge, and a write in the fifth cycle is ignored.
- R7: After a selection-loading write, the mask stays at 1 until the first retire pulse presented after the write's cycle. A retire pulse in the write's own cycle does not release it.
- R8: The vector base is 0 when the selection is 0 and equals the BOOT_BASE parameter (default 0x1C00) when the selection is 1.
- R9: When the selection is 1, lock_app is high and in_boot is low, the mask output is 1.
- R10: When the selection is 0, lock_boot is high and in_boot is high, the mask output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_arm | input | 1 | Written value of the arming bit |
| wr_sel | input | 1 | Written value of the selection bit |
| retire | input | 1 | One-cycle pulse at instruction completion |
| in_boot | input | 1 | Execution is in the boot region |
| lock_app | input | 1 | Lock option protecting the application region |
| lock_boot | input | 1 | Lock option protecting the boot region |
| vec_sel | output | 1 | Current vector table selection |
| vec_base | output | ADDR_W | Vector table base address |
| irq_mask | output | 1 | Interrupt mask towards the interrupt controller |

## Verification
On every cycle, the assertions check three things. The selection changes only through a zero-arming write inside an open window. An arming write or a loading write is always followed by the mask. Each lock combination forces the mask. The window length itself, the restart of the count by a repeated arming write, the exact cycle in which a late write stops being accepted, and the retire pulse that releases the mask are timing scenarios. Only the bench's scenarios, which count cycles from the arming edge, can show them.

// File: rtl/ivt_reloc.sv
module ivt_reloc #(
  parameter int          ADDR_W    = 16,
  parameter int          WIN       = 4,
  parameter logic [15:0] BOOT_BASE = 16'h1C00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_arm,
  input  logic              wr_sel,
  input  logic              retire,
  input  logic              in_boot,
  input  logic              lock_app,
  input  logic              lock_boot,
  output logic              vec_sel,
  output logic [ADDR_W-1:0] vec_base,
  output logic              irq_mask
);
  localparam int CW = $clog2(WIN + 1);

  logic          armed;
  logic [CW-1:0] cnt;
  logic          hold;
  logic          arm_wr, load_wr, lock_mask;

  assign arm_wr  = wr_en && wr_arm;
  assign load_wr = wr_en && !wr_arm && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      cnt     <= '0;
      vec_sel <= 1'b0;
      hold    <= 1'b0;
    end else begin
      if (arm_wr) begin
        armed <= 1'b1;
        cnt   <= CW'(WIN);
      end else if (load_wr) begin
        armed   <= 1'b0;
        cnt     <= '0;
        vec_sel <= wr_sel;
      end else if (armed) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) armed <= 1'b0;
      end
      if (load_wr)           hold <= 1'b1;
      else if (hold && retire) hold <= 1'b0;
    end
  end

  assign lock_mask = (vec_sel && lock_app && !in_boot) ||
                     (!vec_sel && lock_boot && in_boot);
  assign irq_mask  = armed || hold || lock_mask;
  assign vec_base  = vec_sel ? ADDR_W'(BOOT_BASE) : '0;

  assert_sel_guarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_arm && armed) |=> $stable(vec_sel));
  assert_arm_masks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_arm) |=> irq_mask);
  assert_load_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_arm && armed) |=> (irq_mask && vec_sel == $past(wr_sel)));
  assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt != '0 && cnt <= CW'(WIN)));
  assert_lock_app_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_sel && lock_app && !in_boot) |-> irq_mask);
  assert_lock_boot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_sel && lock_boot && in_boot) |-> irq_mask);
  assert_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_base == (vec_sel ? ADDR_W'(BOOT_BASE) : '0));
endmodule

// File: tb/ivt_reloc_tb.sv
`timescale 1ns/1ps
module ivt_reloc_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_arm = 0, wr_sel = 0, retire = 0;
  logic in_boot = 0, lock_app = 0, lock_boot = 0;
  logic vec_sel, irq_mask;
  logic [15:0] vec_base;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  ivt_reloc u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_arm(wr_arm),
    .wr_sel(wr_sel), .retire(retire), .in_boot(in_boot), .lock_app(lock_app),
    .lock_boot(lock_boot), .vec_sel(vec_sel), .vec_base(vec_base), .irq_mask(irq_mask));

  // entry: [5:2] idle cycles before the loading write, [1] select value
  localparam logic [5:0] VEC [6] = '{
    {4'd0, 1'b1, 1'b0}, {4'd3, 1'b0, 1'b0}, {4'd4, 1'b1, 1'b0},
    {4'd2, 1'b1, 1'b0}, {4'd5, 1'b0, 1'b0}, {4'd1, 1'b0, 1'b0}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic a, input logic s, input logic r);
    wr_en = w; wr_arm = a; wr_sel = s; retire = r;
    @(posedge clk); @(negedge clk);
    wr_en = 0; wr_arm = 0; wr_sel = 0; retire = 0;
  endtask

  initial begin
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic model_sel;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(vec_sel == 0, "R1 sel", vec_sel, 0);
    chk(vec_base == 0, "R1 base", vec_base, 0);
    chk(irq_mask == 0, "R1 mask", irq_mask, 0);
    model_sel = 0;

    for (int i = 0; i < 6; i++) begin
      int d; logic s; bit ok;
      d = int'(VEC[i][5:2]); s = VEC[i][1]; ok = d < 4;
      step(1, 1, 0, 0);
      chk(irq_mask == 1, "R2 mask after arm", irq_mask, 1);
      for (int k = 0; k < d; k++) step(0, 0, 0, 0);
      step(1, 0, s, 0);
      if (ok) model_sel = s;
      chk(vec_sel == model_sel, ok ? "R3 load in window" : "R6 late write", vec_sel, model_sel);
      chk(irq_mask == ok, ok ? "R7 mask held" : "R6 mask released", irq_mask, ok);
      chk(vec_base == (model_sel ? 16'h1C00 : 16'h0), "R8 base", vec_base, model_sel ? 16'h1C00 : 0);
      step(0, 0, 0, 1);
      chk(irq_mask == 0, "R7 released by retire", irq_mask, 0);
    end

    // R4: re-arm inside window, restart count
    step(1, 1, 0, 0);
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    step(1, 1, ~model_sel, 0);
    chk(vec_sel == model_sel, "R4 arm write no load", vec_sel, model_sel);
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    chk(irq_mask == 1, "R4 window restarted", irq_mask, 1);
    step(1, 0, ~model_sel, 0);
    model_sel = ~model_sel;
    chk(vec_sel == model_sel, "R4 load after restart", vec_sel, model_sel);
    // R7: retire in write cycle does not release
    step(0, 0, 0, 0);
    step(1, 1, 0, 0);
    step(1, 0, ~model_sel, 1);
    model_sel = ~model_sel;
    chk(irq_mask == 1, "R7 same-cycle retire", irq_mask, 1);
    step(0, 0, 0, 0);
    chk(irq_mask == 1, "R7 held without retire", irq_mask, 1);
    step(0, 0, 0, 1);
    chk(irq_mask == 0, "R7 release", irq_mask, 0);
    // R5: write outside any window
    step(1, 0, ~model_sel, 0);
    chk(vec_sel == model_sel, "R5 unarmed write", vec_sel, model_sel);
    chk(irq_mask == 0, "R5 no mask", irq_mask, 0);
    // R6: window expiry exactly after four cycles
    step(1, 1, 0, 0);
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    chk(irq_mask == 1, "R6 still open", irq_mask, 1);
    step(0, 0, 0, 0);
    chk(irq_mask == 0, "R6 closed", irq_mask, 0);

    // R9/R10 lock masks; bring selection to 1 first
    if (!model_sel) begin
      step(1, 1, 0, 0); step(1, 0, 1, 0); step(0, 0, 0, 1); model_sel = 1;
    end
    chk(vec_base == 16'h1C00, "R8 boot base", vec_base, 16'h1C00);
    lock_app = 1; in_boot = 0; #1;
    chk(irq_mask == 1, "R9 app lock in app", irq_mask, 1);
    in_boot = 1; #1;
    chk(irq_mask == 0, "R9 app lock in boot", irq_mask, 0);
    lock_app = 0; lock_boot = 1; #1;
    chk(irq_mask == 0, "R10 boot lock with sel 1", irq_mask, 0);
    step(1, 1, 0, 0); step(1, 0, 0, 0); step(0, 0, 0, 1);
    chk(irq_mask == 1, "R10 boot lock in boot", irq_mask, 1);
    in_boot = 0; #1;
    chk(irq_mask == 0, "R10 boot lock in app", irq_mask, 0);
    chk(vec_base == 0, "R8 app base", vec_base, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule